// File: doc/BRIEF.md
# Approximate Reciprocal Square Root Unit

This unit takes one single-precision floating-point operand and returns an estimate of its reciprocal square root. The estimate is good to about twelve bits. It sits in a vector datapath. The estimate fills the low 32-bit lane of the result vector. Lanes 1 to 3 (bits 127:32) are copied from a pass-through source. A mode pin decides what happens to the bits above 127: they either keep the prior contents of the destination or are cleared.

The estimate is built from two parts:
- The result exponent comes straight from the operand exponent field: biased result = (380 - e) >> 1.
- The result significand comes from a table. The table is indexed by the exponent LSB and the top mantissa bits.

The table is filled at elaboration by an integer square-root function, so no contents are written out by hand.

Special operands follow a fixed policy and raise no flags:
- zero and denormal operands give signed infinity;
- negative operands give the default NaN;
- NaNs are quieted and passed back;
- +infinity gives +0.

No rounding mode applies.

Data enters and leaves on valid/ready handshakes. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high. The result is registered and shown on the next edge with `out_valid` high. While `out_valid` is high and `out_ready` is low, the result stays frozen and `in_ready` stays low. `in_ready` is high whenever the output register is empty or being drained in the same cycle, so a non-stalled stream runs at one operand per cycle.

Top module: `rsqrt_unit`

## Requirements
- R1: For every positive normal operand, the relative error of the lane result against the exact 1/sqrt(x) is at most 1.5 × 2^-12.
- R2: An operand of +0 or -0 yields infinity of the same sign (0x7F800000 or 0xFF800000).
- R3: An operand whose exponent field is 0 and mantissa is nonzero (a denormal) is taken as a zero of the same sign and yields the matching signed infinity.
- R4: Any operand with sign bit 1, other than a zero, a denormal or a NaN, yields 0xFFC00000. This includes negative infinity.
- R5: A NaN operand (exponent field 0xFF, nonzero mantissa) is returned with mantissa bit 22 set and all other bits unchanged, so a quiet NaN passes through as it is.
- R6: An operand of +infinity (0x7F800000) yields +0 (0x00000000).
- R7: Result bits 127:32 equal the `pass_hi` value taken with the operand.
- R8: With `zero_upper` low, result bits above 127 equal the `dest_hi` value taken with the operand.
- R9: With `zero_upper` high, result bits above 127 are all zero.
- R10: An operand taken on one clock edge has its result on the outputs, with `out_valid` high, from the next clock edge.
- R11: While `out_valid` is high and `out_ready` is low, `res_vec` and `out_valid` hold and `in_ready` is low.
- R12: For a positive normal operand with exponent field e, the result exponent field is (380 - e) >> 1.
- R13: During reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can take an operand this cycle |
| op_lane | input | 32 | Low 32-bit lane of the operand vector |
| pass_hi | input | 96 | Bits 127:32 of the pass-through source |
| dest_hi | input | VLEN-128 | Prior destination contents above bit 127 |
| zero_upper | input | 1 | 1: clear bits above 127; 0: keep `dest_hi` |
| out_valid | output | 1 | Result vector valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| res_vec | output | VLEN | Merged result vector |

## Verification
A bad table entry shows up only as a result outside the error bound. It appears in the cycle after an operand in that table slot is taken. The bench therefore sweeps mantissas under both exponent parities and checks every positive normal result against a real-valued reference.

A wrong class decision shows up as a wrong lane word in the next cycle, so each special class is driven directly. A bad valid flag or a bad hold under stall shows up as lost, duplicated or altered results. The scoreboard catches these when it pops, while random back-pressure is applied.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

  typedef enum logic [2:0] {
    CLS_NORM,
    CLS_ZERO,
    CLS_NEG,
    CLS_PINF,
    CLS_NAN
  } op_class_e;

  typedef struct packed {
    logic        sign;
    logic [7:0]  expo;
    logic [22:0] man;
  } sp_word_t;

  localparam logic [31:0] DEFAULT_NAN = 32'hFFC0_0000;
  localparam logic [7:0]  EXP_MAX     = 8'hFF;

  // floor(sqrt(n)), bit by bit
  function automatic logic [31:0] isqrt64(input logic [63:0] n);
    logic [31:0] r;
    logic [31:0] c;
    r = '0;
    for (int k = 31; k >= 0; k--) begin
      c = r | (32'd1 << k);
      if ((64'(c) * 64'(c)) <= n) r = c;
    end
    return r;
  endfunction

  // Table value, scaled by 2^fracw, for the midpoint of mantissa slot idx.
  // odd_e = 1: even unbiased exponent, value 2/sqrt(s).
  // odd_e = 0: odd unbiased exponent, value sqrt(2)/sqrt(s).
  function automatic logic [31:0] rom_entry(input logic odd_e, input int idx,
                                            input int idxw, input int fracw);
    logic [63:0] num;
    logic [63:0] den;
    num = 64'd1 << (2 * fracw + idxw + 1 + (odd_e ? 2 : 1));
    den = (64'd1 << (idxw + 1)) + 64'(2 * idx + 1);
    return isqrt64(num / den);
  endfunction

endpackage

// File: rtl/rsqrt_class.sv
module rsqrt_class
  import rsqrt_pkg::*;
(
  input  sp_word_t  op,
  output op_class_e cls
);
  logic exp_zero, exp_full, man_nz;

  assign exp_zero = (op.expo == 8'h00);
  assign exp_full = (op.expo == EXP_MAX);
  assign man_nz   = |op.man;

  // order: NaN, zero/denormal, negative, +inf, normal
  always_comb begin
    if (exp_full && man_nz)  cls = CLS_NAN;
    else if (exp_zero)       cls = CLS_ZERO;
    else if (op.sign)        cls = CLS_NEG;
    else if (exp_full)       cls = CLS_PINF;
    else                     cls = CLS_NORM;
  end
endmodule

// File: rtl/rsqrt_rom.sv
module rsqrt_rom
  import rsqrt_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int FRAC_W = 14
) (
  input  logic              odd_exp,
  input  logic [IDX_W-1:0]  slot,
  output logic [FRAC_W-1:0] frac
);
  localparam int SLOTS = 2 ** IDX_W;
  localparam int DEPTH = 2 * SLOTS;

  logic [FRAC_W-1:0] table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [31:0] ENT = rom_entry(1'(g / SLOTS), g % SLOTS, IDX_W, FRAC_W);
    assign table_q[g] = ENT[FRAC_W-1:0];
  end

  assign frac = table_q[{odd_exp, slot}];
endmodule

// File: rtl/rsqrt_core.sv
module rsqrt_core
  import rsqrt_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int FRAC_W = 14
) (
  input  logic [31:0] op_word,
  output logic [31:0] res_word
);
  sp_word_t          op;
  op_class_e         cls;
  logic [FRAC_W-1:0] frac;
  logic [22:0]       man_res;
  logic [9:0]        exp_diff;
  logic [7:0]        exp_res;

  assign op = sp_word_t'(op_word);

  rsqrt_class u_class (
    .op  (op),
    .cls (cls)
  );

  rsqrt_rom #(.IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_rom (
    .odd_exp (op.expo[0]),
    .slot    (op.man[22 -: IDX_W]),
    .frac    (frac)
  );

  if (FRAC_W < 23) begin : g_pad
    assign man_res = {frac, {(23 - FRAC_W){1'b0}}};
  end else begin : g_cut
    assign man_res = frac[FRAC_W-1 -: 23];
  end

  assign exp_diff = 10'd380 - {2'b00, op.expo};
  assign exp_res  = exp_diff[8:1];

  always_comb begin
    unique case (cls)
      CLS_NAN:  res_word = {op.sign, EXP_MAX, 1'b1, op.man[21:0]};
      CLS_ZERO: res_word = {op.sign, EXP_MAX, 23'd0};
      CLS_NEG:  res_word = DEFAULT_NAN;
      CLS_PINF: res_word = 32'd0;
      default:  res_word = {1'b0, exp_res, man_res};
    endcase
  end
endmodule

// File: rtl/rsqrt_unit.sv
module rsqrt_unit #(
  parameter int VLEN   = 256,
  parameter int IDX_W  = 10,
  parameter int FRAC_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      op_lane,
  input  logic [95:0]      pass_hi,
  input  logic [VLEN-129:0] dest_hi,
  input  logic             zero_upper,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VLEN-1:0]  res_vec
);
  localparam int UPPER_W = VLEN - 128;

  logic              accept;
  logic [31:0]       lane_res;
  logic [UPPER_W-1:0] upper;
  logic [VLEN-1:0]   merged;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  rsqrt_core #(.IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_core (
    .op_word  (op_lane),
    .res_word (lane_res)
  );

  assign upper  = zero_upper ? '0 : dest_hi;
  assign merged = {upper, pass_hi, lane_res};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_vec   <= '0;
    end else begin
      if (accept) begin
        res_vec   <= merged;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rsqrt_unit_chk.sv
module rsqrt_unit_chk #(
  parameter int VLEN = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [31:0]       op_lane,
  input logic [95:0]       pass_hi,
  input logic [VLEN-129:0] dest_hi,
  input logic              zero_upper,
  input logic              out_valid,
  input logic              out_ready,
  input logic [VLEN-1:0]   res_vec
);
  logic take;
  logic op_nan;
  assign take   = in_valid && in_ready;
  assign op_nan = (op_lane[30:23] == 8'hFF) && (op_lane[22:0] != 23'd0);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_vec));

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R7
  pass_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> res_vec[127:32] == $past(pass_hi));

  // R8
  keep_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !zero_upper |=> res_vec[VLEN-1:128] == $past(dest_hi));

  // R9
  clear_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && zero_upper |=> res_vec[VLEN-1:128] == '0);

  // R2
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && op_lane[30:23] == 8'h00 |=>
      res_vec[30:0] == 31'h7F80_0000 && res_vec[31] == $past(op_lane[31]));

  // R4
  neg_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && op_lane[31] && op_lane[30:23] != 8'h00 && !op_nan |=>
      res_vec[31:0] == 32'hFFC0_0000);

  // R5
  nan_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && op_nan |=> res_vec[31:0] == ($past(op_lane) | 32'h0040_0000));
endmodule

bind rsqrt_unit rsqrt_unit_chk #(.VLEN(VLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .op_lane    (op_lane),
  .pass_hi    (pass_hi),
  .dest_hi    (dest_hi),
  .zero_upper (zero_upper),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .res_vec    (res_vec)
);

// File: tb/rsqrt_unit_tb.sv
module rsqrt_unit_tb;
  localparam int VLEN = 256;
  localparam int WD_LIMIT = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [31:0]       op_lane = '0;
  logic [95:0]       pass_hi = '0;
  logic [VLEN-129:0] dest_hi = '0;
  logic              zero_upper = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [VLEN-1:0]   res_vec;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic stall = 1'b0;
  logic bp_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  typedef struct {
    logic [31:0]       op;
    logic [95:0]       hi;
    logic [VLEN-129:0] dh;
    logic              zu;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;   // 50 MHz

  rsqrt_unit #(.VLEN(VLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_lane(op_lane), .pass_hi(pass_hi), .dest_hi(dest_hi),
    .zero_upper(zero_upper), .out_valid(out_valid), .out_ready(out_ready),
    .res_vec(res_vec)
  );

  always @(posedge clk) begin
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= stall ? 1'b0 : (bp_rand ? lfsr[3] : 1'b1);
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  function automatic real sp_to_real(input logic [31:0] b);
    real r;
    int  e;
    r = 1.0 + real'(b[22:0]) / 8388608.0;
    e = int'(b[30:23]) - 127;
    if (e > 0) repeat (e) r = r * 2.0;
    else repeat (-e) r = r / 2.0;
    return r;
  endfunction

  // expected lane word for non-normal classes; is_norm set for positive normals
  function automatic logic [31:0] special_lane(input logic [31:0] op, output bit is_norm);
    is_norm = 1'b0;
    if (op[30:23] == 8'hFF && op[22:0] != 0) return op | 32'h0040_0000;   // R5
    if (op[30:23] == 8'h00) return {op[31], 8'hFF, 23'd0};                // R2 R3
    if (op[31]) return 32'hFFC0_0000;                                      // R4
    if (op[30:23] == 8'hFF) return 32'h0;                                  // R6
    is_norm = 1'b1;
    return 32'h0;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10 unexpected result", 128'(res_vec[31:0]), 128'd0);
      end else begin
        item_t it;
        bit nrm;
        logic [31:0] exp_l;
        it = sb_q.pop_front();
        exp_l = special_lane(it.op, nrm);
        chk(res_vec[127:32] == it.hi, "R7", 128'(res_vec[127:32]), 128'(it.hi));
        if (it.zu)
          chk(res_vec[VLEN-1:128] == '0, "R9", 128'(res_vec[VLEN-1:128]), 128'd0);
        else
          chk(res_vec[VLEN-1:128] == it.dh, "R8", 128'(res_vec[VLEN-1:128]), 128'(it.dh));
        if (nrm) begin
          real x, refv, got, rel;
          logic [7:0] ee;
          ee = 8'((10'd380 - {2'b00, it.op[30:23]}) >> 1);
          chk(res_vec[31:23] == {1'b0, ee}, "R12", 128'(res_vec[31:23]), 128'({1'b0, ee}));
          x    = sp_to_real(it.op);
          refv = 1.0 / $sqrt(x);
          got  = sp_to_real(res_vec[31:0]);
          rel  = (got > refv ? got - refv : refv - got) / refv;
          checks++;
          if (rel > 1.5 / 4096.0) begin
            errors++;
            $display("FAIL R1: op %h got %h rel err %e expected <= %e",
                     it.op, res_vec[31:0], rel, 1.5 / 4096.0);
          end
        end else begin
          chk(res_vec[31:0] == exp_l, "R2-class lane (R2 R3 R4 R5 R6)",
              128'(res_vec[31:0]), 128'(exp_l));
        end
      end
    end
  end

  task automatic send(input logic [31:0] op, input logic zu);
    item_t it;
    @(negedge clk);
    it.op = op;
    it.hi = {$urandom, $urandom, $urandom};
    it.dh = {$urandom, $urandom, $urandom, $urandom};
    it.zu = zu;
    op_lane = it.op; pass_hi = it.hi; dest_hi = it.dh; zero_upper = zu;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    sb_q.push_back(it);
    @(posedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      errors++;
      $display("FAIL R10: watchdog got cycle %0d expected < %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    logic [VLEN-1:0] snap;
    // R13 reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R13 out_valid", 128'(out_valid), 128'd0);
    chk(in_ready == 1'b1, "R13 in_ready", 128'(in_ready), 128'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10 latency, no stall
    send(32'h3F80_0000, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R10 latency", 128'(out_valid), 128'd1);

    // R11 stall hold
    stall = 1'b1;
    @(posedge clk);
    send(32'h4080_0000, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    snap = res_vec;
    chk(out_valid == 1'b1, "R11 valid", 128'(out_valid), 128'd1);
    chk(in_ready == 1'b0, "R11 in_ready", 128'(in_ready), 128'd0);
    repeat (3) @(negedge clk);
    chk(res_vec == snap, "R11 hold", 128'(res_vec[127:0]), 128'(snap[127:0]));
    chk(out_valid == 1'b1, "R11 valid held", 128'(out_valid), 128'd1);
    stall = 1'b0;
    repeat (3) @(negedge clk);

    // specials: R2 R3 R4 R5 R6
    send(32'h0000_0000, 1'b0);
    send(32'h8000_0000, 1'b1);
    send(32'h0000_0001, 1'b0);
    send(32'h807F_FFFF, 1'b1);
    send(32'hBF80_0000, 1'b0);
    send(32'hFF80_0000, 1'b1);
    send(32'h7F80_0000, 1'b0);
    send(32'h7F80_0001, 1'b1);
    send(32'hFF81_2345, 1'b0);
    send(32'h7FC0_0000, 1'b1);
    send(32'hFFFF_FFFF, 1'b0);

    // R1 R12 boundaries of exponent and mantissa, both parities
    send(32'h0080_0000, 1'b0);
    send(32'h00FF_FFFF, 1'b1);
    send(32'h7F7F_FFFF, 1'b0);
    send(32'h7F00_0000, 1'b1);
    send(32'h3FFF_FFFF, 1'b0);
    send(32'h4000_0000, 1'b1);

    // R1 sweep under random back-pressure (R11)
    bp_rand = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  e;
      logic [22:0] m;
      e = 8'(1 + ((i * 37) % 254));
      m = 23'(i * 4194301 + i * i * 97);
      send({1'b0, e, m}, 1'(i % 3 == 0));
    end
    @(negedge clk);
    in_valid = 1'b0;
    bp_rand = 1'b0;

    for (int w = 0; w < 200 && sb_q.size() != 0; w++) @(negedge clk);
    chk(sb_q.size() == 0, "R10 drain", 128'(sb_q.size()), 128'd0);
    finish_run();
  end
endmodule